// File: doc/BRIEF.md
# ECG R-Peak Detector with Beat Interval Counter

This block watches a stream of 16-bit unsigned ECG samples, one per clock of a 2 kHz sample clock, and marks each R-peak with a one-cycle trigger. It starts with a learning phase of a fixed number of samples, during which it records the largest and smallest values it sees. From these two extremes it derives a starting threshold. After the learning phase, any sample above the threshold opens a candidate peak. The candidate follows the running maximum, and it is accepted only after a fixed number of further samples have passed without a larger one.

On acceptance the block pulses the trigger and shows the accepted peak value. It then moves the threshold toward the new peak, using adders and shifts only. Because every peak waits through the same confirmation window, the detection latency is constant and does not bias the interval measurement.

A beat-interval counter runs next to the detector. It measures the clock cycles from one trigger to the next and saturates at the top of its 12-bit range. One cycle after each trigger it publishes the measured interval together with a one-cycle valid strobe. The strobe is withheld after the first trigger following reset, because no earlier beat exists to measure from.

Top module: `ecg_peak_detect`

## Requirements
- R1: While rst_ni is low, trigger_o, interval_valid_o, peak_o, interval_o and threshold_o are all 0.
- R2: The first SETUP_CYC samples after reset (default 2000) are learning samples and never cause a trigger. When the edge that captures the last of them has passed, threshold_o equals min + floor((max - min) / 2), where max and min are the extremes of those samples.
- R3: After learning, a sample less than or equal to threshold_o does not start a candidate and does not cause a trigger.
- R4: A sample above threshold_o starts a candidate. Any later sample larger than the candidate replaces it and restarts the confirmation count. trigger_o goes high right after the clock edge that comes VERIFY_CYC edges (default 8) after the edge that captured the final candidate.
- R5: trigger_o is high for exactly one cycle per peak. While it is high, peak_o holds the accepted peak value.
- R6: At the edge that raises trigger_o, the threshold becomes floor((T + floor((P - m) / 2) + m) / 2). Here T is the old threshold, P is the peak and m is the learning minimum. At all other times after learning, the threshold is unchanged.
- R7: One cycle after each trigger other than the first after reset, interval_valid_o is high for one cycle. At the same time interval_o equals the number of clock edges between the edges that raised the two triggers.
- R8: An interval longer than 4095 edges is reported as 4095.
- R9: The first trigger after reset produces no interval_valid_o pulse.
- R10: Asserting rst_ni in the middle of operation clears the learned extremes. A new learning phase of SETUP_CYC samples follows, and it seeds the threshold from the new samples only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one sample per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 16 | Unsigned ECG sample |
| trigger_o | output | 1 | One-cycle pulse on each accepted R-peak |
| peak_o | output | 16 | Value of the most recently accepted peak |
| threshold_o | output | 16 | Current detection threshold |
| interval_o | output | 12 | Last measured beat interval in cycles, saturating |
| interval_valid_o | output | 1 | One-cycle strobe when interval_o is refreshed |

## Verification
A wrong learned extreme or a wrong seed shows up on threshold_o in the cycle right after the last learning sample. A wrong peak or a wrong update rule also corrupts every later threshold, so it shows up at the next trigger. A confirmation counter that fails to restart, or that counts the wrong window, moves trigger_o away from its expected edge; this is visible within VERIFY_CYC cycles of the final candidate. Counter faults appear one cycle after the second trigger as a wrong interval_o, and an arming fault appears as a stray or missing strobe after the first trigger.

// File: rtl/ecg_pkg.sv
package ecg_pkg;
  typedef enum logic {
    ST_SEEK   = 1'b0,
    ST_VERIFY = 1'b1
  } det_state_e;
endpackage

// File: rtl/ecg_thresh.sv
module ecg_thresh #(
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] peak_i,
  output logic              done_o,
  output logic [DATA_W-1:0] thr_o,
  output logic [DATA_W-1:0] min_o
);
  localparam int SW = $clog2(SETUP_CYC + 1);
  localparam logic [SW-1:0] SLAST = SW'(SETUP_CYC - 1);

  logic [DATA_W-1:0] max_q, min_q, thr_q;
  logic [DATA_W-1:0] max_n, min_n, seed;
  logic [SW-1:0]     scnt_q;
  logic              done_q;
  logic [DATA_W+1:0] upd_sum;

  always_comb begin
    max_n   = (sample_i > max_q) ? sample_i : max_q;
    min_n   = (sample_i < min_q) ? sample_i : min_q;
    seed    = min_n + ((max_n - min_n) >> 1);
    upd_sum = {2'b00, thr_q} + {2'b00, ((peak_i - min_q) >> 1)} + {2'b00, min_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q  <= '0;
      min_q  <= '1;
      thr_q  <= '0;
      scnt_q <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      max_q  <= max_n;
      min_q  <= min_n;
      scnt_q <= scnt_q + 1'b1;
      if (scnt_q == SLAST) begin
        done_q <= 1'b1;
        thr_q  <= seed;
      end
    end else if (upd_i) begin
      // sum < 2*peak, so the halved value fits DATA_W bits
      thr_q <= upd_sum[DATA_W:1];
    end
  end

  assign done_o = done_q;
  assign thr_o  = thr_q;
  assign min_o  = min_q;

  p_seed_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (thr_q >= min_q && thr_q <= max_q));

  p_thr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !upd_i) |=> $stable(thr_q));

  p_thr_below_peak_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && upd_i) |=> (thr_q < $past(peak_i)));
endmodule

// File: rtl/ecg_peak_fsm.sv
module ecg_peak_fsm
  import ecg_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int VERIFY_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] thr_i,
  input  logic              done_i,
  output logic              upd_o,
  output logic [DATA_W-1:0] cand_o,
  output logic              trig_o,
  output logic [DATA_W-1:0] peak_o
);
  localparam int VW = (VERIFY_CYC > 1) ? $clog2(VERIFY_CYC) : 1;
  localparam logic [VW-1:0] VLAST = VW'(VERIFY_CYC - 1);

  det_state_e        st_q;
  logic [DATA_W-1:0] cand_q, peak_q;
  logic [VW-1:0]     vcnt_q;
  logic              trig_q;
  logic              bigger, accept;

  always_comb begin
    bigger = sample_i > cand_q;
    accept = (st_q == ST_VERIFY) && !bigger && (vcnt_q == VLAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SEEK;
      cand_q <= '0;
      peak_q <= '0;
      vcnt_q <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      unique case (st_q)
        ST_SEEK: begin
          if (done_i && sample_i > thr_i) begin
            st_q   <= ST_VERIFY;
            cand_q <= sample_i;
            vcnt_q <= '0;
          end
        end
        ST_VERIFY: begin
          if (bigger) begin
            cand_q <= sample_i;
            vcnt_q <= '0;
          end else if (accept) begin
            st_q   <= ST_SEEK;
            peak_q <= cand_q;
            trig_q <= 1'b1;
            vcnt_q <= '0;
          end else begin
            vcnt_q <= vcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_SEEK;
      endcase
    end
  end

  assign upd_o  = accept;
  assign cand_o = cand_q;
  assign trig_o = trig_q;
  assign peak_o = peak_q;

  p_trig_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |=> !trig_q);

  p_trig_after_setup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> done_i);

  p_trig_from_verify_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> (st_q == ST_SEEK && $past(st_q == ST_VERIFY)));

  p_peak_above_thr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEEK && $past(st_q == ST_SEEK) && !trig_q) |-> (cand_q == $past(cand_q)));
endmodule

// File: rtl/ecg_rr_count.sv
module ecg_rr_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  output logic [CNT_W-1:0] interval_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q, ival_q;
  logic             armed_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ival_q  <= '0;
      armed_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (trig_i) begin
        cnt_q   <= CNT_W'(1);
        armed_q <= 1'b1;
        if (armed_q) begin
          ival_q  <= cnt_q;
          valid_q <= 1'b1;
        end
      end else if (cnt_q != CMAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign interval_o = ival_q;
  assign valid_o    = valid_q;

  p_ival_follows_trig_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(trig_i));

  p_sat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && cnt_q == CMAX) |=> (cnt_q == CMAX));

  p_no_first_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !armed_q) |=> !valid_q);
endmodule

// File: rtl/ecg_peak_detect.sv
module ecg_peak_detect #(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 12,
  parameter int SETUP_CYC  = 2000,
  parameter int VERIFY_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  output logic              trigger_o,
  output logic [DATA_W-1:0] peak_o,
  output logic [DATA_W-1:0] threshold_o,
  output logic [CNT_W-1:0]  interval_o,
  output logic              interval_valid_o
);
  logic              done, upd, trig;
  logic [DATA_W-1:0] thr, cand, min_v, peak;

  ecg_thresh #(.DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC)) i_thresh (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_i),
    .upd_i    (upd),
    .peak_i   (cand),
    .done_o   (done),
    .thr_o    (thr),
    .min_o    (min_v)
  );

  ecg_peak_fsm #(.DATA_W(DATA_W), .VERIFY_CYC(VERIFY_CYC)) i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_i),
    .thr_i    (thr),
    .done_i   (done),
    .upd_o    (upd),
    .cand_o   (cand),
    .trig_o   (trig),
    .peak_o   (peak)
  );

  ecg_rr_count #(.CNT_W(CNT_W)) i_rr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig),
    .interval_o (interval_o),
    .valid_o    (interval_valid_o)
  );

  assign trigger_o   = trig;
  assign peak_o      = peak;
  assign threshold_o = thr;

  p_min_below_thr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> (min_v <= thr));
endmodule

// File: tb/test_ecg_peak_detect.sv
module test_ecg_peak_detect;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP      = 2000;
  localparam int VERIFY     = 8;
  localparam int CMAX       = 4095;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] sample_i = '0;
  logic        trigger_o, interval_valid_o;
  logic [15:0] peak_o, threshold_o;
  logic [11:0] interval_o;

  ecg_peak_detect i_ecg_peak_detect (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .sample_i         (sample_i),
    .trigger_o        (trigger_o),
    .peak_o           (peak_o),
    .threshold_o      (threshold_o),
    .interval_o       (interval_o),
    .interval_valid_o (interval_valid_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int edge_n = 0;
  always @(posedge clk_i) edge_n <= edge_n + 1;

  typedef struct {
    int tedge;
    int peak;
    int thr;
    int ival;
    bit ivalid;
  } exp_t;
  exp_t q[$];

  int n_cmp = 0, n_bad = 0, trig_seen = 0;
  int last_trig = 0, cur_thr = 0, cur_min = 0;
  bit armed = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(int v);
    sample_i = 16'(v);
    @(posedge clk_i);
    #1;
  endtask

  // called right after the put that captured the final candidate
  task automatic expect_peak(int pk);
    exp_t e;
    int nt, d;
    e.tedge  = edge_n + VERIFY;
    d        = e.tedge - last_trig;
    e.ival   = armed ? ((d > CMAX) ? CMAX : d) : 0;
    e.ivalid = armed;
    nt       = (cur_thr + (pk - cur_min) / 2 + cur_min) / 2;
    e.peak   = pk;
    e.thr    = nt;
    q.push_back(e);
    last_trig = e.tedge;
    armed     = 1;
    cur_thr   = nt;
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && trigger_o) begin
      trig_seen++;
      if (q.size() == 0) begin
        check(0, "R3 unexpected trigger at edge", edge_n, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(edge_n == e.tedge, "R4 trigger edge", edge_n, e.tedge);
        check(peak_o == 16'(e.peak), "R5 peak value", peak_o, e.peak);
        check(threshold_o == 16'(e.thr), "R6 updated threshold", threshold_o, e.thr);
        @(negedge clk_i);
        check(trigger_o == 1'b0, "R5 trigger width", trigger_o, 0);
        if (e.ivalid) begin
          check(interval_valid_o == 1'b1, "R7 interval strobe", interval_valid_o, 1);
          if (e.ival == CMAX)
            check(interval_o == 12'(e.ival), "R8 saturated interval", interval_o, e.ival);
          else
            check(interval_o == 12'(e.ival), "R7 interval value", interval_o, e.ival);
        end else begin
          check(interval_valid_o == 1'b0, "R9 no strobe on first trigger", interval_valid_o, 0);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog expired", edge_n, -1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1
    check(trigger_o == 0, "R1 trigger in reset", trigger_o, 0);
    check(threshold_o == 0, "R1 threshold in reset", threshold_o, 0);
    check(interval_o == 0 && interval_valid_o == 0, "R1 interval in reset", interval_o, 0);
    check(peak_o == 0, "R1 peak in reset", peak_o, 0);
    rst_ni = 1'b1;

    // R2: extremes 1000 and 2980 -> seed 1990
    for (int i = 0; i < SETUP; i++) put(1000 + (i % 100) * 20);
    check(threshold_o == 16'd1990, "R2 seeded threshold", threshold_o, 1990);
    check(trig_seen == 0, "R2 no trigger in learning", trig_seen, 0);
    cur_thr = 1990; cur_min = 1000; armed = 0;

    repeat (50) put(1500);
    check(trig_seen == 0, "R3 below threshold", trig_seen, 0);

    // R4: running maximum 2500 -> 4000
    put(2500); put(4000); expect_peak(4000); put(3000);
    repeat (30) put(1500);
    check(trig_seen == 1, "R4 first peak", trig_seen, 1);

    // R4: larger sample inside the window restarts it
    put(3000); repeat (5) put(1500); put(3500); expect_peak(3500);
    repeat (30) put(1500);
    check(trig_seen == 2, "R4 restarted peak", trig_seen, 2);

    // R3: sample equal to threshold ignored
    repeat (20) put(cur_thr);
    check(trig_seen == 2, "R3 equal to threshold", trig_seen, 2);
    check(threshold_o == 16'(cur_thr), "R6 threshold held", threshold_o, cur_thr);

    // R8: long gap
    repeat (4200) put(1500);
    put(6000); expect_peak(6000);
    repeat (30) put(1500);

    // R7: short gap
    repeat (5) put(1500);
    put(3000); expect_peak(3000);
    repeat (30) put(1500);
    check(trig_seen == 4, "R7 peak count", trig_seen, 4);

    // R10: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(threshold_o == 0 && peak_o == 0, "R10 cleared threshold and peak", threshold_o, 0);
    check(trigger_o == 0 && interval_valid_o == 0 && interval_o == 0, "R10 cleared outputs", interval_o, 0);
    repeat (2) @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    for (int i = 0; i < SETUP; i++) put((i < 1000) ? 800 : 2000);
    check(threshold_o == 16'd1400, "R10 fresh seed", threshold_o, 1400);
    cur_thr = 1400; cur_min = 800; armed = 0;

    repeat (10) put(1200);
    put(1800); expect_peak(1800);
    repeat (30) put(1200);
    check(trig_seen == 5, "R9 peak after reset", trig_seen, 5);
    check(q.size() == 0, "R4 all expected triggers seen", q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule